// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block computes C = A × B for two square N×N matrices of signed 8-bit integers on a square grid of N×N identical cells. A pulse on `start_i` captures both matrices from flat input buses into an edge feeder. The feeder then drives the left edge with the rows of A and the top edge with the columns of B, each row or column starting one cycle after the one before it. This skew makes a(i,k) and b(k,j) arrive at cell (i,j) in the same cycle.

Each cell multiplies the two operands it receives and adds the product to its own accumulator. It passes the A operand to the right and the B operand downward through registers. Each matrix element is read from the feeder once and is then handed from cell to cell.

The results stay in the cells. When the last cell has consumed its final operand pair, the block raises a one-cycle done flag and presents the result matrix one row per cycle. Inputs that arrive during a computation or its readout are ignored.

Top module: `sysmm_top`

## Requirements
- R1: The grid holds N×N cells. In every compute cycle, cell (i,j) adds the product of the operand at its left input and the operand at its top input to its accumulator. Outside compute cycles the accumulator holds its value.
- R2: Element (i,k) of a matrix is carried on bits [(i*N+k)*8 +: 8] of `a_i` or `b_i`. In compute cycle t (t = 0 is the first), left-edge row i carries a(i,t-i) and top-edge column j carries b(t-j,j). Where that index falls outside 0..N-1, the edge carries zero, so k rises from 0.
- R3: Each cell forwards its left operand to its right neighbour and its top operand to its lower neighbour through one register stage.
- R4: A `start_i` sampled high while idle captures `a_i` and `b_i` and clears every accumulator. Results never carry over from an earlier product.
- R5: `done_o` is high for exactly one cycle. It rises at the (3N-2)-th rising edge after the edge that accepted `start_i`, which is 7 edges for N = 3.
- R6: `row_vld_o` is high for N consecutive cycles, beginning in the cycle in which `done_o` is high. During these cycles `row_idx_o` counts 0 to N-1, and `row_o[j*AW +: AW]` holds C(row_idx_o, j) as two's complement, with AW = 16 + clog2(N+1).
- R7: `start_i` has no effect while `busy_o` is high. Neither the result nor the done timing of the current product changes.
- R8: Operands are signed. The accumulator width holds the sum of N extreme products (for example, every operand -128) without overflow.
- R9: With A = B = [[3,4,2],[2,5,3],[3,2,5]], the result is [[23,36,28],[25,39,34],[28,32,37]].
- R10: `busy_o` is low after reset. It goes high in the cycle after `start_i` is accepted and stays high until the last readout row has been presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture matrices and begin a product (accepted only while idle) |
| a_i | input | N*N*8 | Matrix A, row-major, signed elements |
| b_i | input | N*N*8 | Matrix B, row-major, signed elements |
| busy_o | output | 1 | Computation or readout in progress |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| row_vld_o | output | 1 | `row_o` holds a valid result row |
| row_idx_o | output | max(1,clog2(N)) | Index of the row on `row_o` |
| row_o | output | N*AW | Result row, column j at bits [j*AW +: AW] |

## Verification
The bench builds the block with N = 3. This makes the seven-cycle completion and the worked numerical example directly observable, and it keeps the full skew pattern visible: rows and columns that start late, the centre cell, and the corner cell that finishes last. Directed runs cover the example matrices, sign extremes and an identity. A fixed-seed random set covers mixed signs. Start pulses injected during both the compute and the readout phases check that an active product cannot be disturbed.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_READ = 2'd2
  } mm_state_e;
endpackage

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl
  import sysmm_pkg::*;
#(
  parameter int N  = 3,
  parameter int CW = $clog2(3*N),
  parameter int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          clr_o,
  output logic          en_o,
  output logic [CW-1:0] cnt_o,
  output logic [RW-1:0] ridx_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          row_vld_o
);
  localparam logic [CW-1:0] LAST_T = CW'(3*N-3);
  localparam logic [RW-1:0] LAST_R = RW'(N-1);

  mm_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] ridx_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ridx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: if (cnt_q == LAST_T) begin
          state_q <= ST_READ;
          ridx_q  <= '0;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_READ: if (ridx_q == LAST_R) state_q <= ST_IDLE;
                 else                  ridx_q  <= ridx_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o     = (state_q == ST_IDLE) && start_i;
  assign en_o      = (state_q == ST_RUN);
  assign cnt_o     = cnt_q;
  assign ridx_o    = ridx_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign row_vld_o = (state_q == ST_READ);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R5
  done_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == LAST_T) |=> done_q);
  // R6
  first_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_READ && ridx_q == '0));
  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && start_i && cnt_q != LAST_T) |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sysmm_feeder.sv
module sysmm_feeder #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int CW = $clog2(3*N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_i,
  input  logic            en_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic [N*N*DW-1:0] a_i,
  input  logic [N*N*DW-1:0] b_i,
  output logic [N*DW-1:0] left_o,
  output logic [N*DW-1:0] top_o
);
  logic [N*N*DW-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ld_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // Skewed wavefront: lane r sees element k when cnt == r + k, zero otherwise
  always_comb begin
    left_o = '0;
    top_o  = '0;
    if (en_i) begin
      for (int r = 0; r < N; r++) begin
        for (int k = 0; k < N; k++) begin
          if (int'(cnt_i) == r + k) begin
            left_o[r*DW +: DW] = a_q[(r*N+k)*DW +: DW];
            top_o[r*DW +: DW]  = b_q[(k*N+r)*DW +: DW];
          end
        end
      end
    end
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (left_o == '0 && top_o == '0));
endmodule

// File: rtl/sysmm_pe.sv
module sysmm_pe #(
  parameter int DW = 8,
  parameter int AW = 2*DW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o,
  output logic signed [AW-1:0] acc_o
);
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prod_x;

  assign prod   = a_i * b_i;
  assign prod_x = {{(AW-2*DW){prod[2*DW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_o <= '0;
    end else if (clr_i) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_o <= '0;
    end else begin
      a_o <= a_i;
      b_o <= b_i;
      if (en_i) acc_o <= acc_o + prod_x;
    end
  end

  // R4
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0));
  // R3
  fwd_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (a_o == $past(a_i) && b_o == $past(b_i)));
  // R1
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_o));
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top #(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int AW = 2*DW + $clog2(N+1),
  parameter int RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N*N*DW-1:0] a_i,
  input  logic [N*N*DW-1:0] b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              row_vld_o,
  output logic [RW-1:0]     row_idx_o,
  output logic [N*AW-1:0]   row_o
);
  localparam int CW = $clog2(3*N);

  logic          clr, en;
  logic [CW-1:0] cnt;
  logic [RW-1:0] ridx;
  logic [N*DW-1:0] left, top;

  logic signed [DW-1:0] a_w   [N][N];
  logic signed [DW-1:0] b_w   [N][N];
  logic signed [AW-1:0] acc_w [N][N];

  sysmm_ctrl #(.N(N), .CW(CW), .RW(RW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .clr_o(clr), .en_o(en), .cnt_o(cnt), .ridx_o(ridx),
    .busy_o, .done_o, .row_vld_o
  );

  sysmm_feeder #(.N(N), .DW(DW), .CW(CW)) u_feed (
    .clk_i, .rst_ni, .ld_i(clr), .en_i(en), .cnt_i(cnt),
    .a_i, .b_i, .left_o(left), .top_o(top)
  );

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic signed [DW-1:0] a_in, b_in;
      if (j == 0) begin : g_ledge
        assign a_in = left[i*DW +: DW];
      end else begin : g_lint
        assign a_in = a_w[i][j-1];
      end
      if (i == 0) begin : g_tedge
        assign b_in = top[j*DW +: DW];
      end else begin : g_tint
        assign b_in = b_w[i-1][j];
      end
      sysmm_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i, .rst_ni, .clr_i(clr), .en_i(en),
        .a_i(a_in), .b_i(b_in),
        .a_o(a_w[i][j]), .b_o(b_w[i][j]), .acc_o(acc_w[i][j])
      );
    end
  end

  always_comb begin
    row_o = '0;
    for (int r = 0; r < N; r++)
      if (int'(ridx) == r)
        for (int c = 0; c < N; c++) row_o[c*AW +: AW] = acc_w[r][c];
  end
  assign row_idx_o = ridx;

  // R10
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  // R6
  row_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_vld_o |-> busy_o);
endmodule

// File: tb/sysmm_top_tb.sv
module sysmm_top_tb;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 2*DW + $clog2(N+1);
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*N*DW-1:0] a_v = '0, b_v = '0;
  logic busy, done, row_vld;
  logic [RW-1:0] row_idx;
  logic [N*AW-1:0] row;

  int ma[N][N];
  int mb[N][N];
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sysmm_top #(.N(N), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_v), .b_i(b_v),
    .busy_o(busy), .done_o(done), .row_vld_o(row_vld),
    .row_idx_o(row_idx), .row_o(row)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_c(input int r, input int c);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(ma[r][k]) * longint'(mb[k][c]);
    return s;
  endfunction

  task automatic pack();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        a_v[(r*N+c)*DW +: DW] = DW'(ma[r][c]);
        b_v[(r*N+c)*DW +: DW] = DW'(mb[r][c]);
      end
  endtask

  // One product; optional stray start during compute or readout (R7)
  task automatic run_mm(input string tag, input bit poke_run, input bit poke_read);
    logic [N*N*DW-1:0] keep;
    pack();
    keep = a_v;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    for (int c = 1; c <= 3*N-3; c++) begin
      @(negedge clk);
      if (poke_run && c == 2) begin a_v = ~keep; start = 1'b1; end
      if (poke_run && c == 3) begin a_v = keep;  start = 1'b0; end
      chk(done == 1'b0, "R5", {tag, " done early"}, done, 0);
    end
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      if (r == 0) chk(done == 1'b1, "R5", {tag, " done at 3N-2"}, done, 1);
      else        chk(done == 1'b0, "R5", {tag, " done single"}, done, 0);
      chk(row_vld == 1'b1, "R6", {tag, " row valid"}, row_vld, 1);
      chk(int'(row_idx) == r, "R6", {tag, " row index"}, row_idx, r);
      for (int c = 0; c < N; c++) begin
        longint got = longint'($signed(row[c*AW +: AW]));
        chk(got == ref_c(r, c), poke_run ? "R7" : "R1",
            $sformatf("%s C(%0d,%0d)", tag, r, c), got, ref_c(r, c));
      end
      if (poke_read && r == 1) start = 1'b1;
      if (poke_read && r == 2) start = 1'b0;
      chk(busy == 1'b1, "R10", {tag, " busy in readout"}, busy, 1);
    end
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && row_vld == 1'b0 && done == 1'b0, "R10",
        {tag, " idle after readout"}, {busy, row_vld, done}, 0);
    if (poke_read) begin
      for (int c = 0; c < 3*N; c++) begin
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R7", {tag, " start in readout ignored"},
            {busy, done}, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && row_vld == 1'b0, "R10", "reset state",
        {busy, done, row_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R5", "idle after reset", {busy, done}, 0);

    // R9: worked example
    ma = '{'{3,4,2}, '{2,5,3}, '{3,2,5}};
    mb = ma;
    run_mm("R9 example", 1'b0, 1'b0);
    chk(ref_c(1, 1) == 39, "R9", "reference C(1,1)", ref_c(1, 1), 39);

    // R8: sign extremes
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin
      ma[r][c] = -128; mb[r][c] = -128;
    end
    run_mm("R8 neg extreme", 1'b0, 1'b0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin
      ma[r][c] = 127; mb[r][c] = -128;
    end
    run_mm("R8 mixed extreme", 1'b0, 1'b0);

    // R2/R3: identity times distinct values exposes lane or order errors
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin
      ma[r][c] = (r == c) ? 1 : 0;
      mb[r][c] = r * N + c + 1;
    end
    run_mm("R2 identity left", 1'b0, 1'b0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin
      mb[r][c] = (r == c) ? 1 : 0;
      ma[r][c] = -(r * N + c + 1);
    end
    run_mm("R3 identity right", 1'b0, 1'b0);

    // R7: stray starts during compute and readout
    ma = '{'{1,-2,3}, '{4,5,-6}, '{-7,8,9}};
    mb = '{'{9,8,-7}, '{6,-5,4}, '{3,2,1}};
    run_mm("R7 poke run", 1'b1, 1'b0);
    run_mm("R7 poke read", 1'b0, 1'b1);

    // R4: random products back to back, no carry-over
    for (int n = 0; n < 8; n++) begin
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin
        ma[r][c] = int'($urandom % 256) - 128;
        mb[r][c] = int'($urandom % 256) - 128;
      end
      run_mm($sformatf("R4 random %0d", n), 1'b0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule